// File: doc/BRIEF.md
# Single-bit fifth-order digital noise shaper

This block turns a stream of oversampled signed PCM samples into a one-bit pulse-density stream. It is used between an upsampling stage and a one-bit output driver. Each time the sample strobe is high, one input word is taken and one output bit is produced. Inside is a cascade of five saturating integrators. Two local resonator feedback taps inside the cascade put notches into the in-band noise floor.

The output bit goes straight back into the first adder as a full-scale value: plus full scale for 1, minus full scale for 0. No converter sits in the feedback path. A shift-and-add weighting of the five updated integrator states forms the loop-filter output. The sign of that weighted sum is the new bit. All five integrator updates and the decision finish in one clock cycle. The coefficients are fixed shift amounts, so the datapath has no multipliers.

Top module: `sdm_fifth_order`

## Requirements
- R1: When `rst` is high at a rising clock edge, all five integrator states go to zero, `bit_o` goes to 0 and `sat_o` goes to 0.
- R2: When `en` is low, a clock edge changes neither the integrator states nor `bit_o` nor `sat_o`.
- R3: On an enabled sample, integrator 1 adds `x_i - fb` to its state. Here `fb` is +2^(DW-1) when `bit_o` is 1 and -2^(DW-1) when `bit_o` is 0, both taken before the edge.
- R4: On an enabled sample, integrators 3 and 5 add the old state of the stage before them. Integrator 2 adds the old state of integrator 1 minus (old state of integrator 3 arithmetically shifted right by RES_SH_A). Integrator 4 adds the old state of integrator 3 minus (old state of integrator 5 arithmetically shifted right by RES_SH_B).
- R5: Every integrator result is clamped to the range [-LIM, +LIM] instead of wrapping.
- R6: The new `bit_o` is 1 exactly when the sum over stages k=1..5 of (n_k >>> A_k) + (n_k >>> B_k) is at least zero. Here n_k are the updated states, the shifts are arithmetic (rounding toward minus infinity), A = {0,1,2,4,5} and B = {2,3,4,6,7}.
- R7: `bit_o` changes only on a clock edge where `en` or `rst` is high. The new value is visible right after that same edge.
- R8: `sat_o` is high exactly when at least one integrator state equals +LIM or -LIM. It changes only on an edge where `en` or `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample strobe; one loop update per high cycle |
| x_i | input | DW | Signed two's-complement input sample |
| bit_o | output | 1 | Quantized output; 1 means +full scale, 0 means -full scale |
| sat_o | output | 1 | High while any integrator sits at its limit |

## Verification
Every input level of a narrow configuration is held as a constant input long enough to drive the deep stages into their limits. A model that tracks the integrator states catches a feedback sign error, a resonator tap on the wrong stage or the wrong side of the subtraction, and wrapping in place of clamping. Each of these shows up as a mismatched bit sequence or a missing saturation flag. Arithmetic shifts of negative states are exercised heavily, so a logical shift or an unsigned extension would flip decisions near zero. Random gaps in the strobe would show any state or output that moves without a sample. Resets issued while the loop is saturated would expose state that survives reset.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    // number of cascaded integrators (loop order)
    localparam int unsigned NST = 5;

    // feed-forward weight of stage k is 2^-FF_SHA[k] + 2^-FF_SHB[k]
    localparam int unsigned FF_SHA [NST] = '{0, 1, 2, 4, 5};
    localparam int unsigned FF_SHB [NST] = '{2, 3, 4, 6, 7};

    // headroom bits for the weighted quantizer sum
    localparam int unsigned QGUARD = 3;

    typedef enum logic {
        LVL_NEG = 1'b0,
        LVL_POS = 1'b1
    } level_e;

    typedef struct packed {
        level_e level;
        logic   sat;
    } loop_out_t;

endpackage

// File: rtl/sdm_integ.sv
module sdm_integ #(
    parameter int IW  = 24,
    parameter int AW  = 25,
    parameter int LIM = 2**(IW-1) - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [AW-1:0] add_i,
    output logic signed [IW-1:0] st_o,
    output logic signed [IW-1:0] nxt_o,
    output logic                 at_lim_o
);
    localparam int SW = ((IW > AW) ? IW : AW) + 1;

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lim_p;
    logic signed [SW-1:0] lim_n;
    logic signed [IW-1:0] st_q;

    assign lim_p = SW'(LIM);
    assign lim_n = -lim_p;

    always_comb begin
        sum = SW'(st_q) + SW'(add_i);
        if (sum > lim_p)
            nxt_o = IW'(lim_p);
        else if (sum < lim_n)
            nxt_o = IW'(lim_n);
        else
            nxt_o = IW'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (en)
            st_q <= nxt_o;
    end

    assign st_o     = st_q;
    assign at_lim_o = (st_q == IW'(lim_p)) || (st_q == IW'(lim_n));

endmodule

// File: rtl/sdm_quant.sv
module sdm_quant #(
    parameter int IW = 24
) (
    input  logic signed [IW-1:0] st_i [sdm_pkg::NST],
    output sdm_pkg::level_e      level_o
);
    import sdm_pkg::*;

    localparam int WW = IW + int'(QGUARD);

    logic signed [WW-1:0] term [NST];
    logic signed [WW-1:0] acc;

    for (genvar g = 0; g < int'(NST); g++) begin : g_term
        logic signed [WW-1:0] ext;
        assign ext     = WW'(st_i[g]);
        assign term[g] = (ext >>> FF_SHA[g]) + (ext >>> FF_SHB[g]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < int'(NST); k++)
            acc = acc + term[k];
        level_o = acc[WW-1] ? LVL_NEG : LVL_POS;
    end

endmodule

// File: rtl/sdm_fifth_order.sv
module sdm_fifth_order #(
    parameter int DW       = 16,
    parameter int IW       = 24,
    parameter int LIM      = 2**(IW-1) - 1,
    parameter int RES_SH_A = 6,
    parameter int RES_SH_B = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] x_i,
    output logic                 bit_o,
    output logic                 sat_o
);
    import sdm_pkg::*;

    localparam int AW = IW + 1;
    localparam int FS = 2**(DW-1);

    logic signed [IW-1:0] st  [NST];
    logic signed [IW-1:0] nx  [NST];
    logic signed [AW-1:0] add [NST];
    logic [NST-1:0]       at_lim;
    logic signed [AW-1:0] fb;
    level_e               q_lvl;
    loop_out_t            out_q;

    assign fb = (out_q.level == LVL_POS) ? AW'(FS) : -AW'(FS);

    for (genvar g = 0; g < int'(NST); g++) begin : g_stage
        if (g == 0) begin : g_in
            assign add[g] = AW'(x_i) - fb;
        end else if (g == 1 || g == 3) begin : g_res
            localparam int RSH = (g == 1) ? RES_SH_A : RES_SH_B;
            assign add[g] = AW'(st[g-1]) - AW'(st[g+1] >>> RSH);
        end else begin : g_chain
            assign add[g] = AW'(st[g-1]);
        end

        sdm_integ #(
            .IW (IW),
            .AW (AW),
            .LIM(LIM)
        ) u_integ (
            .clk     (clk),
            .rst     (rst),
            .en      (en),
            .add_i   (add[g]),
            .st_o    (st[g]),
            .nxt_o   (nx[g]),
            .at_lim_o(at_lim[g])
        );
    end

    sdm_quant #(.IW(IW)) u_quant (
        .st_i   (nx),
        .level_o(q_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q.level <= LVL_NEG;
        else if (en)
            out_q.level <= q_lvl;
    end

    always_comb out_q.sat = |at_lim;

    assign bit_o = (out_q.level == LVL_POS);
    assign sat_o = out_q.sat;

endmodule

// File: rtl/sdm_fifth_order_chk.sv
module sdm_fifth_order_chk #(
    parameter int IW  = 24,
    parameter int LIM = 2**(IW-1) - 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 bit_o,
    input logic                 sat_o,
    input logic signed [IW-1:0] s0,
    input logic signed [IW-1:0] s1,
    input logic signed [IW-1:0] s2,
    input logic signed [IW-1:0] s3,
    input logic signed [IW-1:0] s4
);
    localparam logic signed [IW-1:0] LP = IW'(LIM);
    localparam logic signed [IW-1:0] LN = -IW'(LIM);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!bit_o && !sat_o && s0 == 0 && s1 == 0 && s2 == 0 && s3 == 0 && s4 == 0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(bit_o) && $stable(sat_o) && $stable(s0) && $stable(s1)
                 && $stable(s2) && $stable(s3) && $stable(s4)));

    // R5
    state_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (s0 <= LP && s0 >= LN && s1 <= LP && s1 >= LN && s2 <= LP && s2 >= LN
         && s3 <= LP && s3 >= LN && s4 <= LP && s4 >= LN));

    // R7
    bit_change_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_o != $past(bit_o)) |-> ($past(en) || $past(rst)));

    // R8
    sat_change_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_o != $past(sat_o)) |-> ($past(en) || $past(rst)));

endmodule

bind sdm_fifth_order sdm_fifth_order_chk #(
    .IW (IW),
    .LIM(LIM)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .bit_o(bit_o),
    .sat_o(sat_o),
    .s0   (st[0]),
    .s1   (st[1]),
    .s2   (st[2]),
    .s3   (st[3]),
    .s4   (st[4])
);

// File: tb/sdm_fifth_order_tb.sv
module sdm_fifth_order_tb;

    localparam int CLK_P = 10;
    localparam int DW    = 6;
    localparam int IW    = 12;
    localparam int LIM   = 2000;
    localparam int RA    = 3;
    localparam int RB    = 4;
    localparam int FS    = 2**(DW-1);

    localparam int SHA [5] = '{0, 1, 2, 4, 5};
    localparam int SHB [5] = '{2, 3, 4, 6, 7};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 en  = 1'b0;
    logic signed [DW-1:0] x   = '0;
    logic                 bit_o;
    logic                 sat_o;

    int checks = 0;
    int errors = 0;
    bit saw_sat = 1'b0;

    longint ms [5];
    bit     mb;
    bit     msat;

    always #(CLK_P/2) clk = ~clk;

    sdm_fifth_order #(
        .DW(DW), .IW(IW), .LIM(LIM), .RES_SH_A(RA), .RES_SH_B(RB)
    ) u_dut (
        .clk(clk), .rst(rst), .en(en), .x_i(x), .bit_o(bit_o), .sat_o(sat_o)
    );

    function automatic longint clampv(longint v);
        if (v > LIM)  return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 5; k++) ms[k] = 0;
        mb   = 1'b0;
        msat = 1'b0;
    endtask

    // R3 feedback, R4 chain and resonators, R5 clamp, R6 decision
    task automatic model_step(int xv);
        longint a [5];
        longint n [5];
        longint w;
        longint fbv;
        fbv  = mb ? FS : -FS;
        a[0] = xv - fbv;
        a[1] = ms[0] - (ms[2] >>> RA);
        a[2] = ms[1];
        a[3] = ms[2] - (ms[4] >>> RB);
        a[4] = ms[3];
        w    = 0;
        msat = 1'b0;
        for (int k = 0; k < 5; k++) begin
            n[k] = clampv(ms[k] + a[k]);
            w    = w + (n[k] >>> SHA[k]) + (n[k] >>> SHB[k]);
            if (n[k] == LIM || n[k] == -LIM) msat = 1'b1;
        end
        for (int k = 0; k < 5; k++) ms[k] = n[k];
        mb = (w >= 0);
    endtask

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_outputs(string req_bit, string req_sat);
        check_eq(req_bit, longint'(bit_o), longint'(mb));
        check_eq(req_sat, longint'(sat_o), longint'(msat));
        if (sat_o) saw_sat = 1'b1;
    endtask

    // one clock: drive at negedge, compare at following negedge
    task automatic cycle(bit e, int xv);
        en = e;
        x  = DW'(xv);
        @(negedge clk);
        if (e) model_step(xv);
        if (e) compare_outputs("R6", "R8");   // R7 visible after the same edge
        else   compare_outputs("R2", "R2");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b1;
        x   = DW'(FS - 1);
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
        model_reset();
        compare_outputs("R1", "R1");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs cleared after power-on reset
        compare_outputs("R1", "R1");

        // DC sweep over every input code (R3, R4, R5, R6, R7, R8)
        for (int xv = -FS; xv < FS; xv++) begin
            do_reset();
            for (int s = 0; s < 40; s++) cycle(1'b1, xv);
        end

        // R5: full-scale drive must reach the clamp and report it
        do_reset();
        saw_sat = 1'b0;
        for (int s = 0; s < 200; s++) cycle(1'b1, -FS);
        check_eq("R5", longint'(saw_sat), 1);

        // R1: reset while saturated clears everything
        do_reset();
        for (int s = 0; s < 30; s++) cycle(1'b1, 0);

        // R2: random input with random strobe gaps
        do_reset();
        lfsr = 16'hACE1;
        for (int s = 0; s < 2000; s++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0] | lfsr[3], int'($signed(lfsr[DW+1:2])));
        end

        // R2: long idle with changing input after saturation
        for (int s = 0; s < 100; s++) cycle(1'b1, FS - 1);
        for (int s = 0; s < 20; s++) cycle(1'b0, -FS + s);
        for (int s = 0; s < 20; s++) cycle(1'b1, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule